// File: doc/BRIEF.md
# Load/Store Address Check Unit

This unit sits at the front of a load/store pipe. Each cycle it may accept one memory operation, given as a base register value, a 16-bit offset, an access kind and a direction. It forms the effective address and decides whether the access may go to memory or must trap. The decision covers three things: whether coprocessor 1 is usable, whether 64-bit operation is enabled, and whether the address is aligned for the access size.

One cycle after an operation is accepted, the unit presents one of two results. Either it raises a memory request strobe with the size-aligned address, or it raises an exception strobe with a cause code, the faulting address and a coprocessor-error field. Translation, the memory itself and the register file belong to other blocks.

Top module: `lsac_top`

## Requirements
- R1: The effective address is base_val plus imm_val sign-extended to ADDR_W bits, with the sum taken modulo 2^ADDR_W.
- R2: Results appear one clock after the input cycle. After a cycle with in_valid low, neither mem_req nor exc_valid is high. Both are low during reset.
- R3: Accesses of the kind word (2), unsigned word (4) or coprocessor-1 word (5) fault when either of address bits [1:0] is set. The cause is 4 for a load and 5 for a store (is_store=1).
- R4: Accesses of the kind doubleword (3) or coprocessor-1 doubleword (6) fault when any of address bits [2:0] is set. The cause is 4 for a load and 5 for a store.
- R5: A halfword (1) access faults when address bit 0 is set, with cause 4 for a load and 5 for a store. A byte (0) access never faults.
- R6: A kind of 5 or 6 with cu1_usable low reports cause 11 with cop_err=1 and issues no request. This check takes priority over every other check.
- R7: A kind of 3 or 4 with wide_en low reports cause 10. Kind 7 is reserved and always reports cause 10. Both take priority over alignment.
- R8: For causes 4 and 5, bad_addr equals the unaligned effective address. For every other accepted operation, bad_addr is 0. cop_err is 0 unless the cause is 11.
- R9: For each accepted operation, exactly one of mem_req and exc_valid is high. mem_addr is the effective address with its low log2(size) bits cleared, where the size is 1, 2, 4 or 8 bytes for kinds 0, 1, {2,4,5} and {3,6} respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An operation is presented this cycle |
| acc_kind | input | 3 | Access kind code (0..7, see R3 to R7 and R9) |
| is_store | input | 1 | 1 for a store, 0 for a load |
| base_val | input | ADDR_W | Base register value |
| imm_val | input | 16 | Signed offset |
| cu1_usable | input | 1 | Coprocessor 1 usable bit from the status word |
| wide_en | input | 1 | 64-bit operation enabled |
| mem_req | output | 1 | Memory request strobe |
| mem_addr | output | ADDR_W | Size-aligned effective address |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | 5 | Cause code (4, 5, 10 or 11) |
| bad_addr | output | ADDR_W | Faulting address for causes 4 and 5 |
| cop_err | output | 2 | Coprocessor number for cause 11 |

## Verification
Faults in the internal checks show up at the ports on the very next clock. A wrong size decode moves the alignment boundary: a misaligned word or doubleword then produces a request instead of cause 4 or 5, or an aligned access traps. A wrong priority order shows a lower-ranked cause, for example 4 where 11 or 10 is expected. A wrong sum or a wrong sign extension shows up in mem_addr or bad_addr, which is why the stimulus includes negative offsets and an address that wraps past zero.

// File: rtl/lsac_pkg.sv
package lsac_pkg;
  localparam int CAUSE_W = 5;
  localparam int COP_W   = 2;

  typedef enum logic [2:0] {
    K_BYTE   = 3'd0,
    K_HALF   = 3'd1,
    K_WORD   = 3'd2,
    K_DWORD  = 3'd3,
    K_UWORD  = 3'd4,
    K_C1WORD = 3'd5,
    K_C1DBL  = 3'd6,
    K_RSVD   = 3'd7
  } acc_kind_e;

  localparam logic [CAUSE_W-1:0] C_NONE  = 5'd0;
  localparam logic [CAUSE_W-1:0] C_RDADR = 5'd4;
  localparam logic [CAUSE_W-1:0] C_WRADR = 5'd5;
  localparam logic [CAUSE_W-1:0] C_ILLEG = 5'd10;
  localparam logic [CAUSE_W-1:0] C_COPUN = 5'd11;

  typedef struct packed {
    logic [1:0] size_lg;
    logic       cop1;
    logic       wide;
    logic       rsvd;
  } kind_info_t;
endpackage

// File: rtl/lsac_agen.sv
module lsac_agen #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sx;

  always_comb begin
    imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    ea_o   = base_i + imm_sx;
  end
endmodule

// File: rtl/lsac_classify.sv
module lsac_classify
  import lsac_pkg::*;
(
  input  logic [2:0]  kind_i,
  output kind_info_t  info_o
);
  always_comb begin
    info_o = '0;
    unique case (acc_kind_e'(kind_i))
      K_BYTE:   info_o.size_lg = 2'd0;
      K_HALF:   info_o.size_lg = 2'd1;
      K_WORD:   info_o.size_lg = 2'd2;
      K_DWORD:  begin info_o.size_lg = 2'd3; info_o.wide = 1'b1; end
      K_UWORD:  begin info_o.size_lg = 2'd2; info_o.wide = 1'b1; end
      K_C1WORD: begin info_o.size_lg = 2'd2; info_o.cop1 = 1'b1; end
      K_C1DBL:  begin info_o.size_lg = 2'd3; info_o.cop1 = 1'b1; end
      K_RSVD:   info_o.rsvd = 1'b1;
      default:  info_o.rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsac_arbiter.sv
module lsac_arbiter
  import lsac_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                valid_i,
  input  logic [ADDR_W-1:0]   ea_i,
  input  kind_info_t          info_i,
  input  logic                store_i,
  input  logic                cu1_ok_i,
  input  logic                wide_en_i,
  output logic                req_o,
  output logic                exc_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [COP_W-1:0]    cop_o,
  output logic [ADDR_W-1:0]   aligned_o,
  output logic [ADDR_W-1:0]   bad_o
);
  localparam int LOW_W = 3;

  logic [LOW_W-1:0] low_mask;
  logic             misal;
  logic             cop_fault;
  logic             mode_fault;

  always_comb begin
    low_mask  = LOW_W'((4'd1 << info_i.size_lg) - 4'd1);
    misal     = |(ea_i[LOW_W-1:0] & low_mask);
    aligned_o = {ea_i[ADDR_W-1:LOW_W], ea_i[LOW_W-1:0] & ~low_mask};

    cop_fault  = info_i.cop1 & ~cu1_ok_i;
    mode_fault = info_i.rsvd | (info_i.wide & ~wide_en_i);

    cause_o = C_NONE;
    cop_o   = '0;
    bad_o   = '0;
    if (cop_fault) begin
      cause_o = C_COPUN;
      cop_o   = COP_W'(1);
    end else if (mode_fault) begin
      cause_o = C_ILLEG;
    end else if (misal) begin
      cause_o = store_i ? C_WRADR : C_RDADR;
      bad_o   = ea_i;
    end

    exc_o = valid_i & (cause_o != C_NONE);
    req_o = valid_i & (cause_o == C_NONE);
  end
endmodule

// File: rtl/lsac_top.sv
module lsac_top
  import lsac_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          acc_kind,
  input  logic                is_store,
  input  logic [ADDR_W-1:0]   base_val,
  input  logic [IMM_W-1:0]    imm_val,
  input  logic                cu1_usable,
  input  logic                wide_en,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                exc_valid,
  output logic [CAUSE_W-1:0]  exc_cause,
  output logic [ADDR_W-1:0]   bad_addr,
  output logic [COP_W-1:0]    cop_err
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]  rst_pipe;
  logic               rst_ok;
  logic [ADDR_W-1:0]  ea;
  kind_info_t         info;
  logic               req_d, exc_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [COP_W-1:0]   cop_d;
  logic [ADDR_W-1:0]  aligned_d, bad_d;
  logic               load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[SYNC_N-1];

  lsac_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
    .base_i (base_val),
    .imm_i  (imm_val),
    .ea_o   (ea)
  );

  lsac_classify u_class (
    .kind_i (acc_kind),
    .info_o (info)
  );

  lsac_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .valid_i   (in_valid),
    .ea_i      (ea),
    .info_i    (info),
    .store_i   (is_store),
    .cu1_ok_i  (cu1_usable),
    .wide_en_i (wide_en),
    .req_o     (req_d),
    .exc_o     (exc_d),
    .cause_o   (cause_d),
    .cop_o     (cop_d),
    .aligned_o (aligned_d),
    .bad_o     (bad_d)
  );

  assign load_en = in_valid;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      mem_req   <= 1'b0;
      exc_valid <= 1'b0;
    end else begin
      mem_req   <= req_d;
      exc_valid <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      mem_addr  <= '0;
      exc_cause <= '0;
      bad_addr  <= '0;
      cop_err   <= '0;
    end else if (load_en) begin
      mem_addr  <= aligned_d;
      exc_cause <= cause_d;
      bad_addr  <= bad_d;
      cop_err   <= cop_d;
    end
  end
endmodule

// File: rtl/lsac_chk.sv
module lsac_chk #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        acc_kind,
  input logic              is_store,
  input logic [ADDR_W-1:0] base_val,
  input logic [IMM_W-1:0]  imm_val,
  input logic              cu1_usable,
  input logic              wide_en,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              exc_valid,
  input logic [4:0]        exc_cause,
  input logic [ADDR_W-1:0] bad_addr,
  input logic [1:0]        cop_err
);
  logic [ADDR_W-1:0] ea_now;
  assign ea_now = base_val + {{(ADDR_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};

  AST_BYTE_EA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(acc_kind) == 3'd0 |-> mem_addr == $past(ea_now)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !mem_req && !exc_valid); // R2
  AST_STORE_NO_READ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && is_store) && exc_valid |-> exc_cause != 5'd4); // R3
  AST_DBL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(acc_kind) == 3'd3 |-> mem_addr[2:0] == 3'd0); // R4
  AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && acc_kind == 3'd0) |-> mem_req); // R5
  AST_COP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (acc_kind == 3'd5 || acc_kind == 3'd6) && !cu1_usable)
      |-> exc_valid && exc_cause == 5'd11 && cop_err == 2'd1); // R6
  AST_WIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (acc_kind == 3'd3 || acc_kind == 3'd4) && !wide_en)
      |-> exc_valid && exc_cause == 5'd10); // R7
  AST_BAD_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && (exc_cause == 5'd4 || exc_cause == 5'd5) |-> bad_addr == $past(ea_now)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> $countones({mem_req, exc_valid}) == 1); // R9
endmodule

bind lsac_top lsac_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ok),
  .in_valid   (in_valid),
  .acc_kind   (acc_kind),
  .is_store   (is_store),
  .base_val   (base_val),
  .imm_val    (imm_val),
  .cu1_usable (cu1_usable),
  .wide_en    (wide_en),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .exc_valid  (exc_valid),
  .exc_cause  (exc_cause),
  .bad_addr   (bad_addr),
  .cop_err    (cop_err)
);

// File: tb/sim_lsac_top.sv
module sim_lsac_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  typedef struct {
    logic          active;
    logic          req;
    logic          exc;
    logic [4:0]    cause;
    logic [AW-1:0] addr;
    logic [AW-1:0] bad;
    logic [1:0]    cop;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    acc_kind;
  logic          is_store;
  logic [AW-1:0] base_val;
  logic [15:0]   imm_val;
  logic          cu1_usable;
  logic          wide_en;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          exc_valid;
  logic [4:0]    exc_cause;
  logic [AW-1:0] bad_addr;
  logic [1:0]    cop_err;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsac_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_kind(acc_kind),
    .is_store(is_store), .base_val(base_val), .imm_val(imm_val),
    .cu1_usable(cu1_usable), .wide_en(wide_en), .mem_req(mem_req),
    .mem_addr(mem_addr), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .bad_addr(bad_addr), .cop_err(cop_err)
  );

  task automatic check(input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [2:0] k, input logic st,
                                 input logic [AW-1:0] b, input logic [15:0] im,
                                 input logic cu1, input logic w64, input string tag);
    exp_t e;
    logic [AW-1:0] ea, mask;
    int lg;
    ea = b + {{48{im[15]}}, im};
    case (k)
      3'd0: lg = 0; 3'd1: lg = 1; 3'd2, 3'd4, 3'd5: lg = 2;
      3'd3, 3'd6: lg = 3; default: lg = 0;
    endcase
    mask = (64'd1 << lg) - 64'd1;
    e.active = 1'b1; e.tag = tag; e.addr = ea & ~mask;
    e.req = 1'b0; e.exc = 1'b1; e.bad = '0; e.cop = 2'd0; e.cause = 5'd0;
    if ((k == 3'd5 || k == 3'd6) && !cu1) begin
      e.cause = 5'd11; e.cop = 2'd1;
    end else if (k == 3'd7 || ((k == 3'd3 || k == 3'd4) && !w64)) begin
      e.cause = 5'd10;
    end else if ((ea & mask) != 0) begin
      e.cause = st ? 5'd5 : 5'd4; e.bad = ea;
    end else begin
      e.req = 1'b1; e.exc = 1'b0;
    end
    return e;
  endfunction

  task automatic op(input logic [2:0] k, input logic st, input logic [AW-1:0] b,
                    input logic [15:0] im, input logic cu1, input logic w64,
                    input string tag);
    @(negedge clk);
    in_valid = 1'b1; acc_kind = k; is_store = st; base_val = b;
    imm_val = im; cu1_usable = cu1; wide_en = w64;
    sb.push_back(model(k, st, b, im, cu1, w64, tag));
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; acc_kind = 3'd0; is_store = 1'b0;
    e.active = 1'b0; e.req = 1'b0; e.exc = 1'b0; e.cause = '0;
    e.addr = '0; e.bad = '0; e.cop = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops one expectation per clock and compares
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "mem_req", AW'(mem_req), AW'(e.req));
      check(e.tag, "exc_valid", AW'(exc_valid), AW'(e.exc));
      if (e.active) begin
        check(e.tag, "mem_addr", mem_addr, e.addr);
        check(e.tag, "bad_addr", bad_addr, e.bad);
        check(e.tag, "cop_err", AW'(cop_err), AW'(e.cop));
        if (e.exc) check(e.tag, "exc_cause", AW'(exc_cause), AW'(e.cause));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; acc_kind = '0; is_store = 1'b0;
    base_val = '0; imm_val = '0; cu1_usable = 1'b0; wide_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R2", "reset mem_req", AW'(mem_req), '0);
    check("R2", "reset exc_valid", AW'(exc_valid), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    op(3'd0, 0, 64'h1000, 16'hFFFF, 0, 0, "R1");               // byte, negative offset
    op(3'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0002, 0, 0, "R1"); // wrap past zero
    idle("R2");
    op(3'd0, 0, 64'h2003, 16'h0000, 0, 0, "R5");               // byte odd: no fault
    op(3'd1, 0, 64'h2001, 16'h0000, 0, 0, "R5");               // half load odd -> 4
    op(3'd1, 1, 64'h2000, 16'h0003, 0, 0, "R5");               // half store odd -> 5
    op(3'd1, 1, 64'h2000, 16'h0002, 0, 0, "R5");               // half aligned
    op(3'd2, 0, 64'h3002, 16'h0000, 0, 0, "R3");               // word load -> 4
    op(3'd2, 1, 64'h3000, 16'h0001, 0, 0, "R3");               // word store -> 5
    op(3'd2, 0, 64'h3010, 16'hFFFC, 0, 0, "R3");               // word aligned
    op(3'd4, 0, 64'h3004, 16'h0000, 0, 0, "R7");               // uword, 64 off -> 10
    op(3'd4, 0, 64'h3006, 16'h0000, 0, 1, "R3");               // uword misaligned -> 4
    op(3'd3, 0, 64'h4001, 16'h0000, 0, 0, "R7");               // dword 64 off beats align
    op(3'd3, 0, 64'h4000, 16'h0008, 0, 1, "R4");               // dword aligned
    op(3'd3, 0, 64'h4004, 16'h0000, 0, 1, "R4");               // bit 2 set -> 4
    op(3'd3, 1, 64'h4000, 16'hFFF9, 0, 1, "R4");               // store -> 5
    op(3'd5, 0, 64'h5001, 16'h0000, 0, 1, "R6");               // cop unusable beats align
    op(3'd6, 0, 64'h5000, 16'h0000, 0, 0, "R6");               // cop unusable
    op(3'd5, 0, 64'h5002, 16'h0000, 1, 0, "R3");               // cp1 word misaligned -> 4
    op(3'd6, 0, 64'h5004, 16'h0000, 1, 0, "R4");               // cp1 dbl misaligned -> 4
    op(3'd6, 0, 64'h5008, 16'h0000, 1, 0, "R9");               // cp1 dbl ok without 64
    op(3'd7, 0, 64'h6000, 16'h0000, 1, 1, "R7");               // reserved kind -> 10
    op(3'd2, 0, 64'h7003, 16'h0000, 1, 1, "R8");               // bad address capture
    op(3'd2, 0, 64'h7000, 16'h0000, 1, 1, "R8");               // bad address cleared
    idle("R2");
    op(3'd1, 0, 64'h8002, 16'h8000, 1, 1, "R9");               // aligned, large negative
    repeat (3) idle("R2");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule